// File: doc/BRIEF.md
# Operating Mode and Clock Gating Controller

This block holds the power and clock operating mode of a small microcontroller. Every cycle it looks at the mode-request bits, the oscillator-enable bits and the clock-select bit from the control registers. From these it decides four things: which of the two oscillators (high-frequency and low-frequency) is enabled, whether the CPU and peripheral clocks are gated off, whether the time-base timer keeps its clock, and which oscillator clocks the CPU. With a high-frequency source the machine cycle is four high-clock periods, and with a low-frequency source it is four low-clock periods. The consumer of the select output applies that divide.

There are four run modes. High-only and dual-oscillator run the CPU from the high clock. Low-select-dual and low-only run it from the low clock. Each run mode has a halt variant that an interrupt pulse ends. The high-only and low-only run modes also have a time-base halt variant, which only a falling edge on the selected time-base tap ends. A full stop turns both oscillators off and is ended by the stop pin. On that release the machine returns to the run mode it left, which it stored on entry. All control inputs are plain levels sampled on the rising clock edge. There is no data stream and no handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous active-high `rst` forces mode code 0 (reset state). In that state the gate tuple {hosc_run, losc_run, cpu_clk_en, periph_clk_en, tbt_clk_en, cpu_clk_sel} is 100000. On the first edge with `rst` low the mode becomes 1 (high-only run). Every mode change appears on the clock edge that samples its trigger.
- R2: The gate tuple is fixed by the mode. Mode 1 gives 101110, mode 2 (dual run) gives 111110, mode 3 (low-select dual run) gives 111111 and mode 4 (low-only run) gives 011111. Whenever the CPU clock is enabled, the oscillator it is selected from is running.
- R3: With no halt request pending, the oscillator and select bits move between run modes. In mode 1, `losc_bit`=1 goes to 2. In mode 2, `losc_bit`=0 goes to 1, and otherwise `clk_sel_bit`=1 goes to 3. In mode 3, `clk_sel_bit`=0 goes to 2, and otherwise `hosc_bit`=0 goes to 4. In mode 4, `hosc_bit`=1 goes to 3.
- R4: `idle_req` halts the CPU while keeping the oscillators: 1 goes to 5, 2 to 6, 3 to 7 and 4 to 8. `irq_pulse` returns each of 5 to 8 to its run mode. Without it the mode holds.
- R5: `tbhalt_req` moves mode 1 to 9 and mode 4 to 10. These modes return to their run mode only on a falling edge of the time-base tap picked by `tb_sel`. `irq_pulse` has no effect on them.
- R6: `stop_req` in mode 1, 2 or 4 enters mode 11 (stop) and records the run mode. In mode 3, `stop_req` is ignored. In mode 11, `stop_pin`=1 returns to the recorded mode, and `irq_pulse` does not release it.
- R7: When several requests are set in a run mode, stop wins over time-base halt, which wins over idle, which wins over the oscillator and select bits.
- R8: In a run mode, a request of `clk_sel_bit`=1 with `losc_bit`=0, or of `clk_sel_bit`=0 with `hosc_bit`=0, leaves the mode unchanged. It sets `src_err`, which stays set until `rst`.
- R9: In modes 5 to 11, the request, enable and select bits have no effect on the mode.
- R10: Modes 5 and 9 give tuple 100010, mode 6 gives 110010, modes 7 gives 110011, and modes 8 and 10 give 010011. In these modes the CPU and peripheral clocks are off and the time-base clock is on. Mode 11 gives 000000.
- R11: Only the tap selected by `tb_sel` can release a time-base halt. A falling edge on any other tap leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Halt-CPU request bit |
| stop_req | input | 1 | Full-stop request bit |
| tbhalt_req | input | 1 | Time-base halt request bit |
| hosc_bit | input | 1 | High-oscillator enable bit |
| losc_bit | input | 1 | Low-oscillator enable bit |
| clk_sel_bit | input | 1 | CPU clock select bit, 1 = low clock |
| irq_pulse | input | 1 | Interrupt wake pulse |
| stop_pin | input | 1 | External stop-release input, active high |
| tb_taps | input | TB_TAPS | Time-base divider taps |
| tb_sel | input | TB_SEL_W | Index of the tap used for time-base wake |
| mode_code | output | 4 | Current mode code |
| hosc_run | output | 1 | High oscillator enable |
| losc_run | output | 1 | Low oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| periph_clk_en | output | 1 | Peripheral clock gate |
| tbt_clk_en | output | 1 | Time-base timer clock gate |
| cpu_clk_sel | output | 1 | CPU clock source, 1 = low clock |
| src_err | output | 1 | Sticky invalid clock request flag |

## Verification
The main transition graph is walked as one long chain. It passes through every run mode in both the climbing and the falling direction, and enters and leaves every halt variant, so that a wrong successor or a wrong return mode shows up at once in the mode code and the gate tuple. Each wake source is paired with the wrong wake source (an interrupt against a time-base halt and against stop, a level low tick against a true falling edge, an edge on an unselected tap), which separates the correct release condition from any stray one. Requests are also stacked three deep and applied in a mode that must refuse them. Invalid select and enable combinations are applied before and after a reset, which shows that the error flag is sticky and that only reset clears it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_RESET     = 4'd0,
    MD_RUN_HI    = 4'd1,
    MD_RUN_DUAL  = 4'd2,
    MD_RUN_LOWD  = 4'd3,
    MD_RUN_LO    = 4'd4,
    MD_HALT_HI   = 4'd5,
    MD_HALT_DUAL = 4'd6,
    MD_HALT_LOWD = 4'd7,
    MD_HALT_LO   = 4'd8,
    MD_TBH_HI    = 4'd9,
    MD_TBH_LO    = 4'd10,
    MD_STOP      = 4'd11
  } mode_e;

  typedef struct packed {
    logic hosc;
    logic losc;
    logic cpu;
    logic per;
    logic tbt;
    logic sel;
  } gates_t;

  function automatic logic is_run(mode_e m);
    return (m == MD_RUN_HI) || (m == MD_RUN_DUAL) ||
           (m == MD_RUN_LOWD) || (m == MD_RUN_LO);
  endfunction

  function automatic logic is_irq_halt(mode_e m);
    return (m == MD_HALT_HI) || (m == MD_HALT_DUAL) ||
           (m == MD_HALT_LOWD) || (m == MD_HALT_LO);
  endfunction

  function automatic logic is_tb_halt(mode_e m);
    return (m == MD_TBH_HI) || (m == MD_TBH_LO);
  endfunction

  // Halt variant entered by an idle request from a run mode
  function automatic mode_e halt_of(mode_e m);
    case (m)
      MD_RUN_HI:   return MD_HALT_HI;
      MD_RUN_DUAL: return MD_HALT_DUAL;
      MD_RUN_LOWD: return MD_HALT_LOWD;
      MD_RUN_LO:   return MD_HALT_LO;
      default:     return m;
    endcase
  endfunction

  // Run mode a halt variant wakes into
  function automatic mode_e run_of(mode_e m);
    case (m)
      MD_HALT_HI, MD_TBH_HI:   return MD_RUN_HI;
      MD_HALT_DUAL:            return MD_RUN_DUAL;
      MD_HALT_LOWD:            return MD_RUN_LOWD;
      MD_HALT_LO, MD_TBH_LO:   return MD_RUN_LO;
      default:                 return m;
    endcase
  endfunction

  // One step along the run-mode chain driven by the oscillator/select bits
  function automatic mode_e clk_step(mode_e m, logic h, logic l, logic s);
    case (m)
      MD_RUN_HI:   return l ? MD_RUN_DUAL : MD_RUN_HI;
      MD_RUN_DUAL: return !l ? MD_RUN_HI : (s ? MD_RUN_LOWD : MD_RUN_DUAL);
      MD_RUN_LOWD: return !s ? MD_RUN_DUAL : (!h ? MD_RUN_LO : MD_RUN_LOWD);
      MD_RUN_LO:   return h ? MD_RUN_LOWD : MD_RUN_LO;
      default:     return m;
    endcase
  endfunction

endpackage

// File: rtl/pmc_tick_edge.sv
module pmc_tick_edge #(
  parameter int TAPS  = 4,
  parameter int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAPS-1:0]  taps,
  input  logic [SEL_W-1:0] sel,
  output logic             fall
);

  logic tap_now;
  logic tap_q;

  generate
    if (TAPS == 1) begin : g_single
      assign tap_now = taps[0];
    end else begin : g_mux
      assign tap_now = (int'(sel) < TAPS) ? taps[sel] : 1'b0;
    end
  endgenerate

  // A reset value of 0 keeps a tap that is already low from looking like an edge
  always_ff @(posedge clk) begin
    if (rst) tap_q <= 1'b0;
    else     tap_q <= tap_now;
  end

  assign fall = tap_q & ~tap_now;

  p_fall_needs_high_r5: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(tap_now));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  idle_req,
  input  logic  stop_req,
  input  logic  tbh_req,
  input  logic  hosc_bit,
  input  logic  losc_bit,
  input  logic  sel_bit,
  input  logic  irq,
  input  logic  stop_pin,
  input  logic  tick_fall,
  output mode_e mode_o,
  output logic  err_o
);

  mode_e state_q, state_d;
  mode_e saved_q, saved_d;
  logic  err_q, err_set;
  logic  src_bad;

  // Select bit asks for a clock whose oscillator bit is clear
  assign src_bad = (sel_bit && !losc_bit) || (!sel_bit && !hosc_bit);

  always_comb begin
    state_d = state_q;
    saved_d = saved_q;
    err_set = 1'b0;
    case (state_q)
      MD_RESET: state_d = MD_RUN_HI;
      MD_RUN_HI, MD_RUN_DUAL, MD_RUN_LOWD, MD_RUN_LO: begin
        if (stop_req && (state_q != MD_RUN_LOWD)) begin
          state_d = MD_STOP;
          saved_d = state_q;
        end else if (tbh_req && (state_q == MD_RUN_HI)) begin
          state_d = MD_TBH_HI;
        end else if (tbh_req && (state_q == MD_RUN_LO)) begin
          state_d = MD_TBH_LO;
        end else if (idle_req) begin
          state_d = halt_of(state_q);
        end else if (src_bad) begin
          err_set = 1'b1;
        end else begin
          state_d = clk_step(state_q, hosc_bit, losc_bit, sel_bit);
        end
      end
      MD_HALT_HI, MD_HALT_DUAL, MD_HALT_LOWD, MD_HALT_LO: begin
        if (irq) state_d = run_of(state_q);
      end
      MD_TBH_HI, MD_TBH_LO: begin
        if (tick_fall) state_d = run_of(state_q);
      end
      MD_STOP: begin
        if (stop_pin) state_d = saved_q;
      end
      default: state_d = MD_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MD_RESET;
      saved_q <= MD_RUN_HI;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      saved_q <= saved_d;
      err_q   <= err_q | err_set;
    end
  end

  assign mode_o = state_q;
  assign err_o  = err_q;

  p_irq_halt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (is_irq_halt(state_q) && !irq) |=> $stable(state_q));

  p_tb_halt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (is_tb_halt(state_q) && !tick_fall) |=> $stable(state_q));

  p_stop_return_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == MD_STOP && stop_pin) |=> (state_q == $past(saved_q)));

  p_saved_is_run_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == MD_STOP) |-> is_run(saved_q));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  p_bad_src_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (is_run(state_q) && !stop_req && !tbh_req && !idle_req && src_bad)
      |=> ($stable(state_q) && err_q));

endmodule

// File: rtl/pmc_gate_decode.sv
module pmc_gate_decode
  import pmc_pkg::*;
(
  input  mode_e  mode,
  output gates_t gates
);

  // Field order: hosc, losc, cpu, per, tbt, sel
  always_comb begin
    case (mode)
      MD_RESET:     gates = 6'b100000;
      MD_RUN_HI:    gates = 6'b101110;
      MD_RUN_DUAL:  gates = 6'b111110;
      MD_RUN_LOWD:  gates = 6'b111111;
      MD_RUN_LO:    gates = 6'b011111;
      MD_HALT_HI:   gates = 6'b100010;
      MD_HALT_DUAL: gates = 6'b110010;
      MD_HALT_LOWD: gates = 6'b110011;
      MD_HALT_LO:   gates = 6'b010011;
      MD_TBH_HI:    gates = 6'b100010;
      MD_TBH_LO:    gates = 6'b010011;
      MD_STOP:      gates = 6'b000000;
      default:      gates = 6'b000000;
    endcase
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int TB_TAPS  = 4,
  parameter int TB_SEL_W = (TB_TAPS > 1) ? $clog2(TB_TAPS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idle_req,
  input  logic                stop_req,
  input  logic                tbhalt_req,
  input  logic                hosc_bit,
  input  logic                losc_bit,
  input  logic                clk_sel_bit,
  input  logic                irq_pulse,
  input  logic                stop_pin,
  input  logic [TB_TAPS-1:0]  tb_taps,
  input  logic [TB_SEL_W-1:0] tb_sel,
  output logic [MODE_W-1:0]   mode_code,
  output logic                hosc_run,
  output logic                losc_run,
  output logic                cpu_clk_en,
  output logic                periph_clk_en,
  output logic                tbt_clk_en,
  output logic                cpu_clk_sel,
  output logic                src_err
);

  logic   tick_fall;
  mode_e  mode;
  gates_t gates;

  pmc_tick_edge #(
    .TAPS  (TB_TAPS),
    .SEL_W (TB_SEL_W)
  ) u_tick (
    .clk  (clk),
    .rst  (rst),
    .taps (tb_taps),
    .sel  (tb_sel),
    .fall (tick_fall)
  );

  pmc_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .idle_req  (idle_req),
    .stop_req  (stop_req),
    .tbh_req   (tbhalt_req),
    .hosc_bit  (hosc_bit),
    .losc_bit  (losc_bit),
    .sel_bit   (clk_sel_bit),
    .irq       (irq_pulse),
    .stop_pin  (stop_pin),
    .tick_fall (tick_fall),
    .mode_o    (mode),
    .err_o     (src_err)
  );

  pmc_gate_decode u_dec (
    .mode  (mode),
    .gates (gates)
  );

  assign mode_code     = mode;
  assign hosc_run      = gates.hosc;
  assign losc_run      = gates.losc;
  assign cpu_clk_en    = gates.cpu;
  assign periph_clk_en = gates.per;
  assign tbt_clk_en    = gates.tbt;
  assign cpu_clk_sel   = gates.sel;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_code == 4'd0 && !cpu_clk_en && !periph_clk_en && !tbt_clk_en));

  p_cpu_src_running_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (cpu_clk_sel ? losc_run : hosc_run));

  p_halt_gates_r10: assert property (@(posedge clk) disable iff (rst)
    (is_irq_halt(mode) || is_tb_halt(mode)) |-> (!cpu_clk_en && !periph_clk_en && tbt_clk_en));

  p_stop_all_off_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_STOP) |-> !(hosc_run || losc_run || tbt_clk_en || cpu_clk_en));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

  localparam int TAPS = 4;
  localparam int NV   = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle_req = 0, stop_req = 0, tbhalt_req = 0;
  logic hosc_bit = 1, losc_bit = 0, clk_sel_bit = 0;
  logic irq_pulse = 0, stop_pin = 0;
  logic [TAPS-1:0] tb_taps = '1;
  logic [1:0] tb_sel = 2'd0;
  logic [3:0] mode_code;
  logic hosc_run, losc_run, cpu_clk_en, periph_clk_en, tbt_clk_en, cpu_clk_sel, src_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.TB_TAPS(TAPS)) u_dut (
    .clk(clk), .rst(rst), .idle_req(idle_req), .stop_req(stop_req),
    .tbhalt_req(tbhalt_req), .hosc_bit(hosc_bit), .losc_bit(losc_bit),
    .clk_sel_bit(clk_sel_bit), .irq_pulse(irq_pulse), .stop_pin(stop_pin),
    .tb_taps(tb_taps), .tb_sel(tb_sel), .mode_code(mode_code),
    .hosc_run(hosc_run), .losc_run(losc_run), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .tbt_clk_en(tbt_clk_en),
    .cpu_clk_sel(cpu_clk_sel), .src_err(src_err)
  );

  // {stop,tbh,idle}, {hosc,losc,sel}, {irq,pin,tick}, exp mode, exp err, requirement
  localparam logic [17:0] VEC [NV] = '{
    {3'b001, 3'b100, 3'b001, 4'd5,  1'b0, 4'd4},  // R4 idle from high-only
    {3'b000, 3'b100, 3'b001, 4'd5,  1'b0, 4'd4},  // R4 no irq, hold
    {3'b000, 3'b100, 3'b101, 4'd1,  1'b0, 4'd4},  // R4 irq wake
    {3'b000, 3'b110, 3'b001, 4'd2,  1'b0, 4'd3},  // R3 low osc on
    {3'b001, 3'b110, 3'b001, 4'd6,  1'b0, 4'd4},  // R4 idle from dual
    {3'b100, 3'b110, 3'b001, 4'd6,  1'b0, 4'd9},  // R9 stop ignored in halt
    {3'b000, 3'b110, 3'b101, 4'd2,  1'b0, 4'd4},  // R4 wake to dual
    {3'b000, 3'b111, 3'b001, 4'd3,  1'b0, 4'd3},  // R3 select low clock
    {3'b100, 3'b111, 3'b001, 4'd3,  1'b0, 4'd6},  // R6 stop refused in mode 3
    {3'b001, 3'b111, 3'b001, 4'd7,  1'b0, 4'd4},  // R4 idle from mode 3
    {3'b000, 3'b111, 3'b101, 4'd3,  1'b0, 4'd4},  // R4 wake to mode 3
    {3'b000, 3'b011, 3'b001, 4'd4,  1'b0, 4'd3},  // R3 high osc off
    {3'b000, 3'b010, 3'b001, 4'd4,  1'b1, 4'd8},  // R8 high clock asked, osc off
    {3'b010, 3'b011, 3'b001, 4'd10, 1'b1, 4'd5},  // R5 time-base halt low
    {3'b000, 3'b011, 3'b101, 4'd10, 1'b1, 4'd5},  // R5 irq ignored
    {3'b000, 3'b011, 3'b000, 4'd4,  1'b1, 4'd5},  // R5 tick falls, wake
    {3'b001, 3'b011, 3'b000, 4'd8,  1'b1, 4'd4},  // R4 idle from low-only
    {3'b000, 3'b011, 3'b100, 4'd4,  1'b1, 4'd4},  // R4 wake to low-only
    {3'b100, 3'b011, 3'b000, 4'd11, 1'b1, 4'd6},  // R6 stop from low-only
    {3'b000, 3'b011, 3'b000, 4'd11, 1'b1, 4'd6},  // R6 no pin, hold
    {3'b000, 3'b011, 3'b100, 4'd11, 1'b1, 4'd6},  // R6 irq does not release
    {3'b000, 3'b011, 3'b010, 4'd4,  1'b1, 4'd6},  // R6 pin returns to low-only
    {3'b000, 3'b111, 3'b000, 4'd3,  1'b1, 4'd3},  // R3 high osc back on
    {3'b000, 3'b110, 3'b000, 4'd2,  1'b1, 4'd3},  // R3 back to high clock
    {3'b000, 3'b100, 3'b000, 4'd1,  1'b1, 4'd3},  // R3 low osc off
    {3'b000, 3'b101, 3'b000, 4'd1,  1'b1, 4'd8}   // R8 low clock asked, osc off
  };

  function automatic int exp_gates(int m);
    case (m)
      0:  return 6'b100000;
      1:  return 6'b101110;
      2:  return 6'b111110;
      3:  return 6'b111111;
      4:  return 6'b011111;
      5:  return 6'b100010;
      6:  return 6'b110010;
      7:  return 6'b110011;
      8:  return 6'b010011;
      9:  return 6'b100010;
      10: return 6'b010011;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int gates_now();
    return {hosc_run, losc_run, cpu_clk_en, periph_clk_en, tbt_clk_en, cpu_clk_sel};
  endfunction

  task automatic chk_mode(input string tag, input int exp_m, input int exp_e);
    chk({tag, " mode"}, mode_code, exp_m);
    chk({tag, " err"}, src_err, exp_e);
    chk({tag, " gates R2/R10"}, gates_now(), exp_gates(exp_m));
  endtask

  task automatic clear_reqs();
    idle_req = 0; stop_req = 0; tbhalt_req = 0; irq_pulse = 0; stop_pin = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_mode("R1 held in reset", 0, 0);
    rst = 0;
    step();
    chk_mode("R1 first cycle after reset", 1, 0);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      {stop_req, tbhalt_req, idle_req} = v[17:15];
      {hosc_bit, losc_bit, clk_sel_bit} = v[14:12];
      {irq_pulse, stop_pin} = v[11:10];
      tb_taps = {TAPS{v[9]}};
      step();
      chk($sformatf("R%0d vector %0d mode", v[3:0], i), mode_code, v[8:5]);
      chk($sformatf("R%0d vector %0d err", v[3:0], i), src_err, v[4]);
      chk($sformatf("R2/R10 vector %0d gates", i), gates_now(), exp_gates(v[8:5]));
    end

    // R1 and R8: reset clears the sticky flag
    clear_reqs();
    hosc_bit = 1; losc_bit = 0; clk_sel_bit = 0;
    tb_taps = '1; tb_sel = 2'd2;
    rst = 1;
    step();
    chk_mode("R1 reset again, R8 flag cleared", 0, 0);
    rst = 0;
    step();
    chk_mode("R1 release", 1, 0);

    // R7: all three requests at once, stop wins
    stop_req = 1; tbhalt_req = 1; idle_req = 1;
    step();
    chk_mode("R7 stop wins", 11, 0);
    clear_reqs();
    stop_pin = 1;
    step();
    chk_mode("R6 release to high-only", 1, 0);
    clear_reqs();

    // R7: time-base halt wins over idle
    tbhalt_req = 1; idle_req = 1;
    step();
    chk_mode("R7 time-base halt wins", 9, 0);
    clear_reqs();
    irq_pulse = 1;
    step();
    chk_mode("R5 irq ignored in time-base halt", 9, 0);
    irq_pulse = 0;

    // R11: only tap 2 releases
    tb_taps = 4'b1110;
    step();
    chk_mode("R11 unselected tap falls", 9, 0);
    tb_taps = 4'b1010;
    step();
    chk_mode("R11 selected tap falls", 1, 0);

    // R6: stop from dual and return there
    losc_bit = 1;
    step();
    chk_mode("R3 dual", 2, 0);
    stop_req = 1;
    step();
    chk_mode("R6 stop from dual", 11, 0);
    stop_req = 0; losc_bit = 0; clk_sel_bit = 1;
    step();
    chk_mode("R9 bits ignored in stop", 11, 0);
    clk_sel_bit = 0; losc_bit = 1; stop_pin = 1;
    step();
    chk_mode("R6 return to dual", 2, 0);
    stop_pin = 0;

    // R8: invalid request in high-only, then sticky
    losc_bit = 0;
    step();
    chk_mode("R3 back to high-only", 1, 0);
    clk_sel_bit = 1;
    step();
    chk_mode("R8 select without low osc", 1, 1);
    clk_sel_bit = 0;
    step();
    chk_mode("R8 flag sticky", 1, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule